// File: doc/BRIEF.md
# Programmable Timing State Sequencer

The sequencer walks through a small register table of 16-bit step words. Each word describes one step: how many time-base cycles it lasts, which of two time bases counts those cycles, whether it closes the sequence, and a group of control levels that are held for the step. A start pulse launches the walk at entry 0. Each later step follows in table order until a step flagged as final has run.

The whole block runs on one system clock. The two time bases arrive as single-cycle tick enables: a fast tick and a slow tick. Software loads the table through a simple write port while the sequencer is idle. The control outputs drive a front end: a DAC enable, an output-latch enable, a test-source select, a channel code and three auxiliary control levels. While no sequence is running, every control output is held at 0.

Top module: `state_sequencer`

## Requirements
- R1: After reset, `busy`, `done` and every control output are 0, and every table entry is 0x0000. That word means a count of 0, the fast source, no final flag and all controls off.
- R2: When `wr_en` is high at a clock edge, `wr_data` is stored in entry `wr_addr`. The stored word is used whenever that entry is the active step.
- R3: A `start` sampled high while idle raises `busy` at that edge and makes entry 0 the active step. A `start` sampled while `busy` is high has no effect.
- R4: A non-final step lasts (count + 1) ticks of its selected time base. The count is in word bits 15:11, so count 0 gives 1 tick and count 31 gives 32 ticks. After the last tick the next entry becomes active.
- R5: Word bit 10 selects the time base. With 0, only `fast_tick` advances the step. With 1, only `slow_tick` advances it. Ticks of the other base are ignored.
- R6: Word bit 9 is the final flag. A step with this flag ends the sequence on the first `fast_tick` it sees, whatever its count and bit 10. A step without the flag passes on to the next entry.
- R7: The last table entry always behaves as a final step, whether or not bit 9 is set.
- R8: `busy` falls at the edge where the final step ends. `done` is high for exactly the one cycle that follows.
- R9: While busy, `dac_en` equals word bit 8 OR the global input `dac_force_on`. When `dac_force_on` is 1, `dac_en` is 1 for the whole run.
- R10: While busy, the active word drives the outputs directly: `test_sel` is bit 7 (0 picks channel set 0 and DAC value register 6, 1 picks set 1 and register 7), `latch_en` is bit 6, `aux_ctl` is bits 5:3 and `chan_sel` is bits 2:0.
- R11: While idle, `dac_en`, `latch_en`, `test_sel`, `aux_ctl` and `chan_sel` are 0, even when `dac_force_on` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | IDX_W (3) | Table entry to write |
| wr_data | input | 16 | Step word to store |
| start | input | 1 | Launch pulse, used only while idle |
| fast_tick | input | 1 | Fast time-base enable, one cycle per period |
| slow_tick | input | 1 | Slow time-base enable, one cycle per period |
| dac_force_on | input | 1 | Holds the DAC enable on during a run |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle completion pulse |
| dac_en | output | 1 | DAC enable for the active step |
| latch_en | output | 1 | Output-latch enable for the active step |
| test_sel | output | 1 | Test source select (channel set and DAC register) |
| aux_ctl | output | 3 | Auxiliary per-step control levels |
| chan_sel | output | 3 | Channel select code |

## Verification
The assertions assume that `fast_tick` and `slow_tick` are single-cycle enables in the system clock domain. They also assume that the table is not rewritten while a run uses it. Under these assumptions the active entry can only move on a tick, and a running sequence can only end on a fast tick. The stimulus writes the table only between runs, and it draws the tick enables from $urandom at fixed rates. It also sends extra start pulses during runs, to exercise the rule that these pulses are ignored.

// File: rtl/seq_pkg.sv
package seq_pkg;
   localparam int unsigned WORD_W   = 16;
   localparam int unsigned REP_W    = 5;
   localparam int unsigned AUX_W    = 3;
   localparam int unsigned CHAN_W   = 3;
   localparam int unsigned REP_LSB  = 11;
   localparam int unsigned SRC_BIT  = 10;
   localparam int unsigned STOP_BIT = 9;
   localparam int unsigned DAC_BIT  = 8;
   localparam int unsigned TST_BIT  = 7;
   localparam int unsigned LAT_BIT  = 6;
   localparam int unsigned AUX_LSB  = 3;
   localparam int unsigned CHAN_LSB = 0;

   typedef struct packed {
      logic [REP_W-1:0]  count;
      logic              slow_src;
      logic              final_step;
      logic              dac_on;
      logic              test_src;
      logic              latch_on;
      logic [AUX_W-1:0]  aux;
      logic [CHAN_W-1:0] chan;
   } step_t;

   function automatic step_t unpack_step(input logic [WORD_W-1:0] w);
      step_t s;
      s.count      = w[REP_LSB +: REP_W];
      s.slow_src   = w[SRC_BIT];
      s.final_step = w[STOP_BIT];
      s.dac_on     = w[DAC_BIT];
      s.test_src   = w[TST_BIT];
      s.latch_on   = w[LAT_BIT];
      s.aux        = w[AUX_LSB +: AUX_W];
      s.chan       = w[CHAN_LSB +: CHAN_W];
      return s;
   endfunction
endpackage

// File: rtl/seq_table.sv
module seq_table #(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned WORD_W = 16,
   localparam int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [WORD_W-1:0] rd_word
);
   logic [WORD_W-1:0] entry_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            entry_q[g] <= '0;
         else if (wr_en && (wr_addr == IDX_W'(g)))
            entry_q[g] <= wr_data;
      end
   end

   assign rd_word = entry_q[rd_idx];
endmodule

// File: rtl/seq_dwell_timer.sv
module seq_dwell_timer #(
   parameter int unsigned REP_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             use_slow,
   input  logic             fast_tick,
   input  logic             slow_tick,
   input  logic [REP_W-1:0] limit,
   output logic             expire
);
   logic [REP_W-1:0] cnt_q;
   logic             tick;

   assign tick   = use_slow ? slow_tick : fast_tick;
   assign expire = run && tick && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || expire)
         cnt_q <= '0;
      else if (tick)
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/seq_step_ctrl.sv
module seq_step_ctrl #(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             fast_tick,
   input  logic             final_flag,
   input  logic             expire,
   output logic             busy,
   output logic             done,
   output logic [IDX_W-1:0] idx
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

   logic             busy_q, busy_d;
   logic             done_q, done_d;
   logic [IDX_W-1:0] idx_q, idx_d;
   logic             at_end;

   assign at_end = final_flag || (idx_q == LAST_IDX);

   always_comb begin
      busy_d = busy_q;
      idx_d  = idx_q;
      done_d = 1'b0;
      if (!busy_q) begin
         if (start) begin
            busy_d = 1'b1;
            idx_d  = '0;
         end
      end else if (at_end) begin
         if (fast_tick) begin
            busy_d = 1'b0;
            done_d = 1'b1;
            idx_d  = '0;
         end
      end else if (expire) begin
         idx_d = idx_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         idx_q  <= '0;
      end else begin
         busy_q <= busy_d;
         done_q <= done_d;
         idx_q  <= idx_d;
      end
   end

   assign busy = busy_q;
   assign done = done_q;
   assign idx  = idx_q;
endmodule

// File: rtl/seq_out_gate.sv
module seq_out_gate
   import seq_pkg::*;
(
   input  logic              active,
   input  logic              force_dac,
   input  step_t             step,
   output logic              dac_en,
   output logic              latch_en,
   output logic              test_sel,
   output logic [AUX_W-1:0]  aux_ctl,
   output logic [CHAN_W-1:0] chan_sel
);
   always_comb begin
      dac_en   = 1'b0;
      latch_en = 1'b0;
      test_sel = 1'b0;
      aux_ctl  = '0;
      chan_sel = '0;
      if (active) begin
         dac_en   = step.dac_on | force_dac;
         latch_en = step.latch_on;
         test_sel = step.test_src;
         aux_ctl  = step.aux;
         chan_sel = step.chan;
      end
   end
endmodule

// File: rtl/state_sequencer.sv
module state_sequencer
   import seq_pkg::*;
#(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              start,
   input  logic              fast_tick,
   input  logic              slow_tick,
   input  logic              dac_force_on,
   output logic              busy,
   output logic              done,
   output logic              dac_en,
   output logic              latch_en,
   output logic              test_sel,
   output logic [AUX_W-1:0]  aux_ctl,
   output logic [CHAN_W-1:0] chan_sel
);
   if (DEPTH < 2 || DEPTH > 256) begin : g_bad_depth
      $error("state_sequencer: DEPTH must lie in 2..256");
   end
   if ((1 << IDX_W) != DEPTH) begin : g_bad_pow2
      $error("state_sequencer: DEPTH must be a power of two");
   end
   if (REP_W + 5 + AUX_W + CHAN_W != WORD_W) begin : g_bad_layout
      $error("state_sequencer: step word fields do not fill the word");
   end

   logic [IDX_W-1:0]  act_idx;
   logic [WORD_W-1:0] act_word;
   step_t             act_step;
   logic              dwell_done;

   seq_table #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_idx  (act_idx),
      .rd_word (act_word)
   );

   assign act_step = unpack_step(act_word);

   seq_dwell_timer #(.REP_W(REP_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (busy),
      .use_slow  (act_step.slow_src),
      .fast_tick (fast_tick),
      .slow_tick (slow_tick),
      .limit     (act_step.count),
      .expire    (dwell_done)
   );

   seq_step_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .fast_tick  (fast_tick),
      .final_flag (act_step.final_step),
      .expire     (dwell_done),
      .busy       (busy),
      .done       (done),
      .idx        (act_idx)
   );

   seq_out_gate u_gate (
      .active    (busy),
      .force_dac (dac_force_on),
      .step      (act_step),
      .dac_en    (dac_en),
      .latch_en  (latch_en),
      .test_sel  (test_sel),
      .aux_ctl   (aux_ctl),
      .chan_sel  (chan_sel)
   );
endmodule

// File: rtl/state_sequencer_chk.sv
module state_sequencer_chk #(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned IDX_W = $clog2(DEPTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             fast_tick,
   input logic             slow_tick,
   input logic             dac_force_on,
   input logic             busy,
   input logic             done,
   input logic             dac_en,
   input logic             latch_en,
   input logic             test_sel,
   input logic [2:0]       aux_ctl,
   input logic [2:0]       chan_sel,
   input logic             act_final,
   input logic [IDX_W-1:0] act_idx
);
   a_r3_start_launches: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && start |=> busy && (act_idx == '0));

   a_r3_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      busy && start && !fast_tick && !slow_tick |=> busy && $stable(act_idx));

   a_r5_no_tick_no_move: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !fast_tick && !slow_tick |=> $stable(act_idx));

   a_r6_final_one_fast: assert property (@(posedge clk) disable iff (!rst_n)
      busy && act_final && fast_tick |=> !busy);

   a_r8_end_on_fast: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !fast_tick |=> busy);

   a_r8_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r9_force_dac: assert property (@(posedge clk) disable iff (!rst_n)
      busy && dac_force_on |-> dac_en);

   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !dac_en && !latch_en && !test_sel && (aux_ctl == '0) && (chan_sel == '0));
endmodule

bind state_sequencer state_sequencer_chk #(.DEPTH(DEPTH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .fast_tick    (fast_tick),
   .slow_tick    (slow_tick),
   .dac_force_on (dac_force_on),
   .busy         (busy),
   .done         (done),
   .dac_en       (dac_en),
   .latch_en     (latch_en),
   .test_sel     (test_sel),
   .aux_ctl      (aux_ctl),
   .chan_sel     (chan_sel),
   .act_final    (act_step.final_step),
   .act_idx      (act_idx)
);

// File: tb/tb_state_sequencer.sv
module tb_state_sequencer;
   localparam int DEPTH = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        start = 1'b0;
   logic        fast_tick = 1'b0;
   logic        slow_tick = 1'b0;
   logic        dac_force_on = 1'b0;
   logic        busy, done, dac_en, latch_en, test_sel;
   logic [2:0]  aux_ctl, chan_sel;

   int checks = 0;
   int errors = 0;

   logic [15:0] m_tbl [DEPTH];
   logic        m_busy = 1'b0;
   logic        m_done = 1'b0;
   int          m_idx = 0;
   int          m_cnt = 0;

   always #10 clk = ~clk;

   state_sequencer #(.DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .start(start), .fast_tick(fast_tick), .slow_tick(slow_tick),
      .dac_force_on(dac_force_on), .busy(busy), .done(done), .dac_en(dac_en),
      .latch_en(latch_en), .test_sel(test_sel), .aux_ctl(aux_ctl), .chan_sel(chan_sel)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_ctl(input logic b, input logic [15:0] w);
      return b ? {w[6], w[7], w[5:3], w[2:0]} : 8'h00;
   endfunction

   // Compare every output against the bench model (R8, R9, R10, R11)
   task automatic compare();
      logic [15:0] w;
      w = m_busy ? m_tbl[m_idx] : 16'h0000;
      chk("R8", "busy", 32'(busy), 32'(m_busy));
      chk("R8", "done", 32'(done), 32'(m_done));
      chk(m_busy ? "R9" : "R11", "dac_en", 32'(dac_en),
          32'(m_busy & (w[8] | dac_force_on)));
      chk(m_busy ? "R10" : "R11", "controls",
          32'({latch_en, test_sel, aux_ctl, chan_sel}), 32'(exp_ctl(m_busy, w)));
   endtask

   // Next-state model built from R2..R8
   task automatic model_step();
      logic [15:0] w;
      logic        tk;
      if (!m_busy) begin
         m_done = 1'b0;
         if (start) begin
            m_busy = 1'b1;
            m_idx  = 0;
            m_cnt  = 0;
         end
      end else begin
         m_done = 1'b0;
         w = m_tbl[m_idx];
         if (w[9] || m_idx == DEPTH - 1) begin
            if (fast_tick) begin
               m_busy = 1'b0;
               m_done = 1'b1;
            end
         end else begin
            tk = w[10] ? slow_tick : fast_tick;
            if (tk) begin
               if (m_cnt == int'(w[15:11])) begin
                  m_idx++;
                  m_cnt = 0;
               end else begin
                  m_cnt++;
               end
            end
         end
      end
      if (wr_en) m_tbl[wr_addr] = wr_data;
   endtask

   task automatic cyc();
      @(posedge clk);
      #1 model_step();
      @(negedge clk);
      compare();
   endtask

   task automatic write_entry(input int a, input logic [15:0] d);
      wr_en = 1'b1;
      wr_addr = 3'(a);
      wr_data = d;
      cyc();
      wr_en = 1'b0;
   endtask

   task automatic run_len(output int len);
      len = 0;
      start = 1'b1;
      cyc();
      start = 1'b0;
      while (busy === 1'b1 && len < 5000) begin
         len++;
         cyc();
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int len;
      void'($urandom(32'd20240517));
      for (int i = 0; i < DEPTH; i++) m_tbl[i] = 16'h0000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1", "busy after reset", 32'(busy), 32'd0);
      chk("R1", "done after reset", 32'(done), 32'd0);
      chk("R1", "outputs after reset", 32'({dac_en, latch_en, test_sel, aux_ctl, chan_sel}), 32'd0);

      // R1 + R7: zeroed table, one fast tick per entry, last entry ends it
      fast_tick = 1'b1;
      run_len(len);
      chk("R7", "run length with zero table", 32'(len), 32'd8);
      cyc();

      // R6: final step ignores count 31 and slow source
      write_entry(0, 16'hFE00);
      run_len(len);
      chk("R6", "final step length", 32'(len), 32'd1);
      cyc();

      // R4 + R2: count 3 on fast, then final
      write_entry(0, 16'h1800);
      write_entry(1, 16'h0200);
      run_len(len);
      chk("R4", "count 3 step plus final", 32'(len), 32'd5);
      cyc();

      // R5 + R3: slow source ignores fast ticks; start during busy ignored
      write_entry(0, 16'h15C5);
      start = 1'b1;
      cyc();
      for (int k = 0; k < 10; k++) cyc();
      start = 1'b0;
      chk("R5", "slow step held by fast ticks only", 32'(busy), 32'd1);
      chk("R10", "chan_sel of entry 0", 32'(chan_sel), 32'd5);
      chk("R10", "latch_en of entry 0", 32'(latch_en), 32'd1);
      chk("R10", "test_sel of entry 0", 32'(test_sel), 32'd1);
      dac_force_on = 1'b1;
      #1 chk("R9", "forced dac_en", 32'(dac_en), 32'd1);
      for (int k = 0; k < 3; k++) begin
         slow_tick = 1'b1;
         cyc();
         slow_tick = 1'b0;
         cyc();
      end
      while (m_busy) cyc();
      chk("R8", "done after slow run", 32'(done), 32'd1);
      cyc();
      chk("R8", "done single cycle", 32'(done), 32'd0);
      chk("R11", "idle dac_en with force", 32'(dac_en), 32'd0);
      dac_force_on = 1'b0;

      // Random programs
      for (int s = 0; s < 25; s++) begin
         for (int e = 0; e < DEPTH; e++) begin
            logic [15:0] w;
            w = 16'($urandom);
            w[9] = ($urandom % 5 == 0);
            if (w[10]) w[15:11] = 5'($urandom % 6);
            write_entry(e, w);
         end
         dac_force_on = ($urandom % 3 == 0);
         start = 1'b1;
         fast_tick = 1'b0;
         cyc();
         start = 1'b0;
         while (m_busy) begin
            fast_tick = ($urandom % 2 == 0);
            slow_tick = ($urandom % 6 == 0);
            start = ($urandom % 4 == 0);
            cyc();
         end
         fast_tick = 1'b0;
         slow_tick = 1'b0;
         start = 1'b0;
         cyc();
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule